// File: doc/BRIEF.md
# Adaptive Voltage Setting Sequencer

This block runs once after reset. It programs a supply regulator with a voltage that suits the silicon's process corner. In the first cycle after reset it samples a 9-bit corner code and turns it into an 8-bit voltage-ID byte. It then drives a byte-level I2C master through a small register-style port: one write strobe with a register select and a data byte, plus a status vector and an enable read-back that come back from the master. Over this port it performs a single-register write to the regulator: start, device address, register address, VID byte, stop.

The block watches the master for lost arbitration and for a missing acknowledge, and recovers from each. There are three recovery paths: arbitration lost just after start, arbitration lost during a byte, and NACK. Each path ends in a common wait for the bus to go idle, and then the whole write is tried again. A second fault ends the sequence in a sticky fatal error.

On success the block raises done. It then drops its clock-enable request for the I2C master, and one cycle later drops its own request. The chosen VID stays visible on an output.

Top module: `avs_vid_setter`

## Requirements
- R1: `vid` gives the voltage ID for the corner code sampled in the first cycle after reset. Code 0 gives 0x53. A code with only bit k set, for k from 0 to 6, gives 0x52 minus k. Every other code gives 0x53.
- R2: The first action is a write of 0x00 to register select 0 (control). This write is repeated until `mst_en_rb` reads 0. No other write happens before that.
- R3: A fault-free run issues these writes as {select, byte}, in this order:
  - {0,80}, {3,07}, {0,94}, {3,06}, {1,60}
  - {1,54}, {2,02}
  - {1,VID}, {2,02}
  - {0,90}, {2,02}
  - {0,00}

  Select 1 is data, 2 is status (write-1-to-clear), 3 is interrupt enable.
- R4: Every data write waits for one of two status flags. The first data write of an attempt waits for status bit 0 (data register empty). Each later one waits for status bit 1 (waiting after a byte).
- R5: Status bit 3 (arbitration lost) seen before the address byte leads to these writes:
  - {2,08}, then the dummy byte {1,53}
  - once bit 1 is set: {0,90}, {2,02}
  - once bit 4 (busy) is 0: {0,00}

  After that the write restarts at {0,80}.
- R6: Arbitration lost after a byte has been sent leads to {2,08}. Then the block follows the same wait-stop-idle-restart tail as R5, with no dummy byte.
- R7: Status bit 2 (NACK) leads to {0,90}, {3,04}, {2,04}. Once busy is 0, the block writes {0,00} and restarts.
- R8: When bits 3 and 2 are both set, the arbitration-loss path is taken.
- R9: A fault seen after one retry raises `fatal`. `fatal` stays high until reset, no further writes occur, and done stays low.
- R10: The final {0,00} is written only when busy is 0. `done` then stays high until reset.
- R11: Both clock requests rise together after reset. `i2c_clk_req` falls in the cycle `done` rises, and `seq_clk_req` falls one cycle later.
- R12: During reset there are no writes, and done, fatal and both clock requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| corner_code | input | 9 | Process-corner code, sampled once after reset |
| mst_en_rb | input | 1 | Enable bit read back from the master control register |
| mst_status | input | 5 | Master flags: 4 busy, 3 arbitration lost, 2 NACK, 1 waiting, 0 data empty |
| mst_wr | output | 1 | Register write strobe to the master |
| mst_addr | output | 2 | Register select: 0 control, 1 data, 2 status, 3 interrupt enable |
| mst_wdata | output | 8 | Write data |
| i2c_clk_req | output | 1 | Clock-enable request for the I2C master |
| seq_clk_req | output | 1 | Clock-enable request for this sequencer |
| done | output | 1 | Voltage setting completed |
| fatal | output | 1 | Retries exhausted, sticky |
| vid | output | 8 | Chosen voltage ID |

## Verification
The hardest situations to reach from the ports are faults that appear at one chosen point of the transaction. One example is arbitration loss right after the start condition, as opposed to loss after the register byte. Another is a second fault arriving during the retry. The bench contains a behavioural master that counts bytes since start. It injects arbitration loss, NACK or both at a programmed byte index, for a programmed number of attempts. This reaches each recovery path, the priority case and the fatal escalation on demand. The full 512-value code space is swept on fault-free runs, with varying byte latency and varying numbers of slow enable release.

// File: rtl/avs_pkg.sv
package avs_pkg;
  localparam int SEL_W  = 2;
  localparam int BYTE_W = 8;
  localparam int STAT_W = 5;

  localparam logic [SEL_W-1:0] SEL_CTRL = 2'd0;
  localparam logic [SEL_W-1:0] SEL_DATA = 2'd1;
  localparam logic [SEL_W-1:0] SEL_STAT = 2'd2;
  localparam logic [SEL_W-1:0] SEL_IEN  = 2'd3;

  localparam logic [BYTE_W-1:0] CTL_OFF   = 8'h00;
  localparam logic [BYTE_W-1:0] CTL_ON    = 8'h80;
  localparam logic [BYTE_W-1:0] CTL_START = 8'h94;
  localparam logic [BYTE_W-1:0] CTL_STOP  = 8'h90;

  localparam logic [BYTE_W-1:0] IEN_ALL    = 8'h07;
  localparam logic [BYTE_W-1:0] IEN_NO_DE  = 8'h06;
  localparam logic [BYTE_W-1:0] IEN_NK     = 8'h04;

  localparam logic [BYTE_W-1:0] CLR_WAIT = 8'h02;
  localparam logic [BYTE_W-1:0] CLR_NACK = 8'h04;
  localparam logic [BYTE_W-1:0] CLR_ARB  = 8'h08;

  localparam logic [BYTE_W-1:0] DEV_WRITE = 8'h60;
  localparam logic [BYTE_W-1:0] VREG_ADDR = 8'h54;

  localparam int F_EMPTY = 0;
  localparam int F_WAIT  = 1;
  localparam int F_NACK  = 2;
  localparam int F_ARB   = 3;
  localparam int F_BUSY  = 4;

  typedef enum logic [5:0] {
    S_INIT, S_CLR, S_CLR_CHK, S_EN, S_IEN, S_START,
    W_SLV, S_IEN_DT, S_SLV,
    W_REG, S_REG, S_REG_REL,
    W_VID, S_VID, S_VID_REL,
    W_STOP, S_STOP, S_STOP_REL,
    W_END, S_OFF, S_DONE, S_QUIT,
    A_START, A_DUMMY, A_XFER,
    N_STOP, N_IEN, N_CLR,
    E_STOP, E_STOP_GO, E_REL, E_END, E_OFF,
    S_FATAL
  } seq_state_e;
endpackage

// File: rtl/avs_vid_map.sv
module avs_vid_map #(
  parameter int CODE_W = 9,
  parameter int VID_W  = 8,
  parameter int N_STEP = 7,
  parameter logic [VID_W-1:0] VID_TOP = 8'h53
) (
  input  logic [CODE_W-1:0] code,
  output logic [VID_W-1:0]  vid
);
  logic [N_STEP-1:0] hit;

  for (genvar k = 0; k < N_STEP; k++) begin : g_step
    assign hit[k] = (code == (CODE_W'(1) << k));
  end

  always_comb begin
    vid = VID_TOP;
    for (int k = 0; k < N_STEP; k++)
      if (hit[k]) vid = VID_TOP - VID_W'(k + 1);
  end
endmodule

// File: rtl/avs_seq_fsm.sv
module avs_seq_fsm
  import avs_pkg::*;
#(
  parameter int RETRY_MAX = 1,
  parameter logic [BYTE_W-1:0] DUMMY_BYTE = 8'h53
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] vid,
  input  logic              en_rb,
  input  logic [STAT_W-1:0] status,
  output logic              load_code,
  output logic              wr,
  output logic [SEL_W-1:0]  sel,
  output logic [BYTE_W-1:0] wdata,
  output logic              i2c_req,
  output logic              seq_req,
  output logic              done,
  output logic              fatal
);
  localparam int RTY_W = $clog2(RETRY_MAX + 1);

  seq_state_e        state, state_n;
  logic [RTY_W-1:0]  retry;
  logic              arb, nack, give_up;
  logic              wr_n;
  logic [SEL_W-1:0]  sel_n;
  logic [BYTE_W-1:0] data_n;

  assign arb       = status[F_ARB];
  assign nack      = status[F_NACK];
  assign give_up   = (arb | nack) && (retry >= RTY_W'(RETRY_MAX));
  assign load_code = (state == S_INIT);

  always_comb begin
    state_n = state;
    case (state)
      S_INIT:     state_n = S_CLR;
      S_CLR:      state_n = S_CLR_CHK;
      S_CLR_CHK:  state_n = en_rb ? S_CLR : S_EN;
      S_EN:       state_n = S_IEN;
      S_IEN:      state_n = S_START;
      S_START:    state_n = W_SLV;
      W_SLV: begin
        if (give_up)                state_n = S_FATAL;
        else if (arb)               state_n = A_START;
        else if (nack)              state_n = N_STOP;
        else if (status[F_EMPTY])   state_n = S_IEN_DT;
      end
      S_IEN_DT:   state_n = S_SLV;
      S_SLV:      state_n = W_REG;
      W_REG, W_VID, W_STOP: begin
        if (give_up)                state_n = S_FATAL;
        else if (arb)               state_n = A_XFER;
        else if (nack)              state_n = N_STOP;
        else if (status[F_WAIT])
          state_n = (state == W_REG) ? S_REG : (state == W_VID) ? S_VID : S_STOP;
      end
      S_REG:      state_n = S_REG_REL;
      S_REG_REL:  state_n = W_VID;
      S_VID:      state_n = S_VID_REL;
      S_VID_REL:  state_n = W_STOP;
      S_STOP:     state_n = S_STOP_REL;
      S_STOP_REL: state_n = W_END;
      W_END:      if (!status[F_BUSY]) state_n = S_OFF;
      S_OFF:      state_n = S_DONE;
      S_DONE:     state_n = S_QUIT;
      S_QUIT:     state_n = S_QUIT;
      A_START:    state_n = A_DUMMY;
      A_DUMMY:    state_n = E_STOP;
      A_XFER:     state_n = E_STOP;
      N_STOP:     state_n = N_IEN;
      N_IEN:      state_n = N_CLR;
      N_CLR:      state_n = E_END;
      E_STOP:     if (status[F_WAIT]) state_n = E_STOP_GO;
      E_STOP_GO:  state_n = E_REL;
      E_REL:      state_n = E_END;
      E_END:      if (!status[F_BUSY]) state_n = E_OFF;
      E_OFF:      state_n = S_EN;
      S_FATAL:    state_n = S_FATAL;
      default:    state_n = S_FATAL;
    endcase
  end

  // Write decoded from the state being entered, so it is registered.
  always_comb begin
    wr_n   = 1'b1;
    sel_n  = SEL_CTRL;
    data_n = CTL_OFF;
    case (state_n)
      S_CLR, S_OFF, E_OFF:          begin sel_n = SEL_CTRL; data_n = CTL_OFF;   end
      S_EN:                         begin sel_n = SEL_CTRL; data_n = CTL_ON;    end
      S_IEN:                        begin sel_n = SEL_IEN;  data_n = IEN_ALL;   end
      S_START:                      begin sel_n = SEL_CTRL; data_n = CTL_START; end
      S_IEN_DT:                     begin sel_n = SEL_IEN;  data_n = IEN_NO_DE; end
      S_SLV:                        begin sel_n = SEL_DATA; data_n = DEV_WRITE; end
      S_REG:                        begin sel_n = SEL_DATA; data_n = VREG_ADDR; end
      S_VID:                        begin sel_n = SEL_DATA; data_n = vid;       end
      S_REG_REL, S_VID_REL,
      S_STOP_REL, E_REL:            begin sel_n = SEL_STAT; data_n = CLR_WAIT;  end
      S_STOP, E_STOP_GO, N_STOP:    begin sel_n = SEL_CTRL; data_n = CTL_STOP;  end
      A_START, A_XFER:              begin sel_n = SEL_STAT; data_n = CLR_ARB;   end
      A_DUMMY:                      begin sel_n = SEL_DATA; data_n = DUMMY_BYTE; end
      N_IEN:                        begin sel_n = SEL_IEN;  data_n = IEN_NK;    end
      N_CLR:                        begin sel_n = SEL_STAT; data_n = CLR_NACK;  end
      default:                      wr_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_INIT;
      retry   <= '0;
      wr      <= 1'b0;
      sel     <= '0;
      wdata   <= '0;
      i2c_req <= 1'b0;
      seq_req <= 1'b0;
      done    <= 1'b0;
      fatal   <= 1'b0;
    end else begin
      state   <= state_n;
      if (state == E_OFF) retry <= retry + 1'b1;
      wr      <= wr_n;
      sel     <= sel_n;
      wdata   <= data_n;
      i2c_req <= !(state_n inside {S_INIT, S_DONE, S_QUIT});
      seq_req <= !(state_n inside {S_INIT, S_QUIT});
      done    <= (state_n inside {S_DONE, S_QUIT});
      fatal   <= (state_n == S_FATAL);
    end
  end
endmodule

// File: rtl/avs_vid_setter.sv
module avs_vid_setter
  import avs_pkg::*;
#(
  parameter int CODE_W    = 9,
  parameter int N_STEP    = 7,
  parameter logic [BYTE_W-1:0] VID_TOP = 8'h53,
  parameter int RETRY_MAX = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] corner_code,
  input  logic              mst_en_rb,
  input  logic [STAT_W-1:0] mst_status,
  output logic              mst_wr,
  output logic [SEL_W-1:0]  mst_addr,
  output logic [BYTE_W-1:0] mst_wdata,
  output logic              i2c_clk_req,
  output logic              seq_clk_req,
  output logic              done,
  output logic              fatal,
  output logic [BYTE_W-1:0] vid
);
  logic [BYTE_W-1:0] vid_map;
  logic              load_code;

  avs_vid_map #(
    .CODE_W(CODE_W), .VID_W(BYTE_W), .N_STEP(N_STEP), .VID_TOP(VID_TOP)
  ) u_map (
    .code(corner_code),
    .vid (vid_map)
  );

  always_ff @(posedge clk) begin
    if (rst)            vid <= VID_TOP;
    else if (load_code) vid <= vid_map;
  end

  avs_seq_fsm #(
    .RETRY_MAX(RETRY_MAX), .DUMMY_BYTE(VID_TOP)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .vid      (vid),
    .en_rb    (mst_en_rb),
    .status   (mst_status),
    .load_code(load_code),
    .wr       (mst_wr),
    .sel      (mst_addr),
    .wdata    (mst_wdata),
    .i2c_req  (i2c_clk_req),
    .seq_req  (seq_clk_req),
    .done     (done),
    .fatal    (fatal)
  );
endmodule

// File: rtl/avs_vid_setter_chk.sv
module avs_vid_setter_chk (
  input logic clk,
  input logic rst,
  input logic mst_wr,
  input logic done,
  input logic fatal,
  input logic i2c_clk_req,
  input logic seq_clk_req
);
  a_r9_fatal_sticky: assert property (@(posedge clk) disable iff (rst)
    fatal |=> fatal);
  a_r9_silent_after_fatal: assert property (@(posedge clk) disable iff (rst)
    fatal |-> !mst_wr);
  a_r9_done_excludes_fatal: assert property (@(posedge clk) disable iff (rst)
    !(done && fatal));
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  a_r11_req_nesting: assert property (@(posedge clk) disable iff (rst)
    i2c_clk_req |-> seq_clk_req);
  a_r11_i2c_drop_on_done: assert property (@(posedge clk) disable iff (rst)
    $fell(i2c_clk_req) |-> done);
  a_r11_seq_drop_late: assert property (@(posedge clk) disable iff (rst)
    $fell(seq_clk_req) |-> $past(done) && !i2c_clk_req);
endmodule

bind avs_vid_setter avs_vid_setter_chk u_chk (
  .clk(clk), .rst(rst), .mst_wr(mst_wr), .done(done), .fatal(fatal),
  .i2c_clk_req(i2c_clk_req), .seq_clk_req(seq_clk_req)
);

// File: tb/avs_vid_setter_tb.sv
`timescale 1ns/1ps
module avs_vid_setter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] corner_code = '0;
  logic       mst_en_rb = 1'b1;
  logic [4:0] mst_status = '0;
  logic       mst_wr;
  logic [1:0] mst_addr;
  logic [7:0] mst_wdata;
  logic       i2c_clk_req, seq_clk_req, done, fatal;
  logic [7:0] vid;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  avs_vid_setter u_dut (
    .clk(clk), .rst(rst), .corner_code(corner_code),
    .mst_en_rb(mst_en_rb), .mst_status(mst_status),
    .mst_wr(mst_wr), .mst_addr(mst_addr), .mst_wdata(mst_wdata),
    .i2c_clk_req(i2c_clk_req), .seq_clk_req(seq_clk_req),
    .done(done), .fatal(fatal), .vid(vid)
  );

  // ---------------- behavioural master ----------------
  int   dly = 3;        // byte/stop latency, >= 2
  int   stick = 0;      // extra disable writes before enable drops
  int   inj_kind = 0;   // 0 none, 1 arb, 2 nack, 3 both
  int   inj_stage = 0;  // 0 after start, n after n-th byte
  int   inj_count = 0;  // attempts that see the fault

  logic [9:0] got [0:63];
  int   got_n;
  int   premature;
  int   off_busy;

  logic [4:0] m_st;
  logic       m_en;
  int   m_stick, m_pend, m_kind, m_byte, m_inj;
  logic m_arb_seen;

  task automatic inject(input int ev);
    if (m_inj > 0 && inj_kind != 0 && inj_stage == m_byte) begin
      m_inj = m_inj - 1;
      if (inj_kind == 1 || inj_kind == 3) begin m_st[3] = 1'b1; m_arb_seen = 1'b1; end
      if (inj_kind == 2 || inj_kind == 3) m_st[2] = 1'b1;
      if (ev == 2 || inj_kind != 1) m_st[1] = 1'b1;
    end else if (ev == 1) m_st[0] = 1'b1;
    else m_st[1] = 1'b1;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_st = '0; m_en = 1'b1; m_stick = stick; m_pend = 0; m_kind = 0;
      m_byte = 0; m_inj = inj_count; m_arb_seen = 1'b0;
      got_n <= 0; premature <= 0; off_busy <= 0;
    end else begin
      if (m_pend == 1) begin
        if (m_kind == 3) m_st[4] = 1'b0;
        else inject(m_kind);
      end
      if (m_pend > 0) m_pend = m_pend - 1;
      if (mst_wr) begin
        if (got_n < 64) begin
          got[got_n] <= {mst_addr, mst_wdata};
          got_n <= got_n + 1;
        end
        case (mst_addr)
          2'd0: begin
            if (mst_wdata == 8'h00) begin
              if (m_st[4]) off_busy <= off_busy + 1;
              if (m_stick > 0) m_stick = m_stick - 1; else m_en = 1'b0;
              m_st = '0; m_pend = 0;
            end else if (mst_wdata == 8'h80) m_en = 1'b1;
            else if (mst_wdata == 8'h94) begin
              m_st[4] = 1'b1; m_byte = 0; m_arb_seen = 1'b0;
              m_pend = dly; m_kind = 1;
            end else if (mst_wdata == 8'h90) begin
              m_pend = dly; m_kind = 3;
            end
          end
          2'd1: begin
            if (!(m_st[0] || m_st[1] || m_arb_seen)) premature <= premature + 1;
            m_st[0] = 1'b0; m_byte = m_byte + 1; m_pend = dly; m_kind = 2;
          end
          2'd2: m_st = m_st & ~mst_wdata[4:0];
          default: ;
        endcase
      end
      mst_status <= m_st;
      mst_en_rb  <= m_en;
    end
  end

  // ---------------- expectation ----------------
  logic [9:0] exp_log [0:63];
  int exp_n;

  task automatic push(input logic [1:0] a, input logic [7:0] d);
    if (exp_n < 64) exp_log[exp_n] = {a, d};
    exp_n = exp_n + 1;
  endtask

  function automatic logic [7:0] exp_vid(input logic [8:0] c);
    logic [7:0] v = 8'h53;
    for (int k = 0; k < 7; k++)
      if (c == (9'd1 << k)) v = 8'h52 - 8'(k);
    return v;
  endfunction

  task automatic build(input logic [8:0] c);
    logic [7:0] v = exp_vid(c);
    exp_n = 0;
    for (int i = 0; i <= stick; i++) push(0, 8'h00);
    for (int a = 0; a < 2; a++) begin
      push(0, 8'h80); push(3, 8'h07); push(0, 8'h94);
      if (a < inj_count && inj_kind != 0) begin
        if (inj_stage >= 1) begin push(3, 8'h06); push(1, 8'h60); end
        if (inj_stage >= 2) begin push(1, 8'h54); push(2, 8'h02); end
        if (inj_stage >= 3) begin push(1, v); push(2, 8'h02); end
        if (a >= 1) return;
        if (inj_kind == 2) begin
          push(0, 8'h90); push(3, 8'h04); push(2, 8'h04); push(0, 8'h00);
        end else begin
          push(2, 8'h08);
          if (inj_stage == 0) push(1, 8'h53);
          push(0, 8'h90); push(2, 8'h02); push(0, 8'h00);
        end
      end else begin
        push(3, 8'h06); push(1, 8'h60); push(1, 8'h54); push(2, 8'h02);
        push(1, v); push(2, 8'h02); push(0, 8'h90); push(2, 8'h02);
        push(0, 8'h00);
        return;
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic run_case(input logic [8:0] c, input string req);
    bit exp_fatal = (inj_count >= 2) && (inj_kind != 0);
    int t = 0;
    bit bad = 0;
    int bad_i = 0;
    rst = 1'b1; corner_code = c;
    build(c);
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    while (!done && !fatal && t < 3000) begin @(negedge clk); t++; end
    check(t < 3000, req, "completion timeout", t, 0);
    if (done) begin
      check(!i2c_clk_req && seq_clk_req, "R11", "reqs at done",
            {i2c_clk_req, seq_clk_req}, 2'b01);
      @(negedge clk);
      check(!seq_clk_req && done, "R11", "seq req next cycle",
            {done, seq_clk_req}, 2'b10);
    end
    repeat (20) @(negedge clk);
    check(fatal == exp_fatal && done == !exp_fatal, "R9", "done/fatal",
          {done, fatal}, {!exp_fatal, exp_fatal});
    for (int i = 0; i < exp_n && i < 64; i++)
      if (!bad && (i >= got_n || got[i] != exp_log[i])) begin bad = 1; bad_i = i; end
    check(!bad && got_n == exp_n, req, "write log",
          bad ? int'(got[bad_i]) : got_n, bad ? int'(exp_log[bad_i]) : exp_n);
    check(premature == 0, "R4", "data written before flag", premature, 0);
    check(off_busy == 0, "R10", "disable while busy", off_busy, 0);
    if (!exp_fatal) check(vid == exp_vid(c), "R1", "vid", vid, exp_vid(c));
  endtask

  initial begin
    #(200000 * 5);
    errors = errors + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R12: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!mst_wr && !done && !fatal && !i2c_clk_req && !seq_clk_req, "R12",
          "reset outputs", {mst_wr, done, fatal, i2c_clk_req, seq_clk_req}, 0);

    // R1 R2 R3 R10 R11: full code sweep, fault free
    for (int c = 0; c < 512; c++) begin
      stick = c % 3; dly = 2 + (c % 4); inj_kind = 0; inj_count = 0;
      run_case(9'(c), "R3");
    end

    stick = 1; dly = 3; inj_count = 1;
    // R5: arbitration loss right after start
    inj_kind = 1; inj_stage = 0; run_case(9'h004, "R5");
    // R6: arbitration loss after each byte
    for (int s = 1; s <= 3; s++) begin
      inj_kind = 1; inj_stage = s; run_case(9'h010, "R6");
    end
    // R7: NACK at every point
    for (int s = 0; s <= 3; s++) begin
      inj_kind = 2; inj_stage = s; run_case(9'h040, "R7");
    end
    // R8: both flags together
    inj_kind = 3; inj_stage = 0; run_case(9'h001, "R8");
    inj_kind = 3; inj_stage = 2; run_case(9'h002, "R8");
    // R9: fault on retry escalates
    inj_count = 2;
    inj_kind = 1; inj_stage = 2; run_case(9'h020, "R9");
    inj_kind = 2; inj_stage = 0; run_case(9'h000, "R9");
    inj_kind = 1; inj_stage = 0; run_case(9'h1FF, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule